// File: doc/BRIEF.md
# Interrupt Status and Acknowledge Controller

This block holds the interrupt status word of a network controller. Event pulses from ten sources are captured as sticky status bits. These sources cover bus faults, transmit completion, control frames, receive progress, host or timer requests, statistics pressure, link changes and two spare sources. A companion enable word masks each sticky bit. The OR of the masked bits drives a single level-sensitive interrupt line, and the same value is reflected in bit 0 of the status word.

Each source has its own way of being acknowledged:

- Some bits clear when software writes a one to them.
- Some clear on strobes from other parts of the chip: a global/DMA reset, an advance of the transmit status queue, the receive DMA draining the FIFO, or completion of a statistics read.
- The receive-early indication retires itself when the frame it warned about finishes arriving.

Top module: `irq_status_ctrl`

## Requirements
- R1: After a synchronous reset (`rst` high on a clock edge) `stat_rdata`, `en_rdata` and `irq_o` are all zero.
- R2: Bit 0 of `stat_rdata` and `irq_o` both equal the OR over bits 1..10 of (status AND enable). Writing bit 0 has no effect on it.
- R3: The enable word keeps `wdata[10:1]` when `en_wr` is high. A cleared enable bit keeps its source from `irq_o`, but it does not stop the status bit from latching.
- R4: Bit 1 (host error) sets on `ev_host_err`. Only `clr_global` clears it; writing 1 to bit 1 leaves it set.
- R5: Bit 2 (transmit done) sets on `ev_tx_done`. It clears on `tx_stat_adv` only when `tx_stat_more` is low. When `tx_stat_more` is high, or when software writes 1 to bit 2, it stays set.
- R6: Bits 3 (`ev_mac_ctrl`), 5 (`ev_rx_early`), 6, 8 (`ev_link`), 9 (`ev_aux[0]`) and 10 (`ev_aux[1]`) clear when `stat_wr` writes a 1 to their position. Writing 0 leaves them unchanged.
- R7: Bit 4 (receive done) sets on `ev_rx_done` and clears on `rx_dma_drained`. Writing 1 to bit 4 leaves it set.
- R8: `ev_rx_done` clears bit 5 on the same edge that sets bit 4, even when `ev_rx_early` pulses in that cycle.
- R9: Bit 6 sets on either `ev_host_req` or `ev_timer`.
- R10: Bit 7 (statistics) sets on `ev_stats_half` and clears on `stats_read_done`. Writing 1 to bit 7 leaves it set.
- R11: When a set event and a clear (write-1 or strobe) hit the same bit in one cycle, the bit ends set. The one exception is R8.
- R12: Bits 15..11 of both `stat_rdata` and `en_rdata` always read zero, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_wr | input | 1 | Write strobe for the status word (write-1 acknowledge) |
| en_wr | input | 1 | Write strobe for the enable word |
| wdata | input | 16 | Write data shared by both words |
| stat_rdata | output | 16 | Status word read value |
| en_rdata | output | 16 | Enable word read value |
| irq_o | output | 1 | Level interrupt request |
| ev_host_err | input | 1 | Bus target/master abort pulse |
| ev_tx_done | input | 1 | Transmit completion or error pulse |
| ev_mac_ctrl | input | 1 | Control frame received pulse |
| ev_rx_done | input | 1 | Whole frame landed in receive FIFO |
| ev_rx_early | input | 1 | Head frame passed early threshold |
| ev_host_req | input | 1 | Host requested interrupt |
| ev_timer | input | 1 | Countdown expired |
| ev_stats_half | input | 1 | A statistics counter near overflow |
| ev_link | input | 1 | Link status changed |
| ev_aux | input | 2 | Spare sources for bits 9 and 10 |
| clr_global | input | 1 | Global or DMA reset strobe |
| tx_stat_adv | input | 1 | Transmit status queue advanced |
| tx_stat_more | input | 1 | Further transmit status entries remain |
| rx_dma_drained | input | 1 | Receive DMA found no complete frames left |
| stats_read_done | input | 1 | Statistics read completed |

## Verification
The bench applies the wrong acknowledge to each strobe-cleared bit, for example a write of 1 to host error or to statistics. A design that treated every bit as write-1-to-clear would lose those events. The bench also fires a set and a clear in the same cycle. A design that let the clear win would drop the event, and a design that let `ev_rx_early` outlive `ev_rx_done` would leave a stale early flag. Transmit-queue advances with entries still pending, masked sources that must still latch, and writes to bit 0 and to the unused upper bits catch a design that clears too early, blocks latching with the mask, or lets a write reach bits that must stay zero.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    localparam int REG_W  = 16;
    localparam int SRC_LO = 1;
    localparam int SRC_HI = 10;
    localparam int AUX_N  = 2;

    localparam int B_HOST_ERR = 1;
    localparam int B_TX_DONE  = 2;
    localparam int B_MAC_CTRL = 3;
    localparam int B_RX_DONE  = 4;
    localparam int B_RX_EARLY = 5;
    localparam int B_REQ      = 6;
    localparam int B_STATS    = 7;
    localparam int B_LINK     = 8;
    localparam int B_AUX0     = 9;

    typedef enum logic [0:0] {
        CLR_BY_W1C    = 1'b0,
        CLR_BY_STROBE = 1'b1
    } clr_kind_e;

    typedef struct packed {
        logic             host_err;
        logic             tx_done;
        logic             mac_ctrl;
        logic             rx_done;
        logic             rx_early;
        logic             host_req;
        logic             timer;
        logic             stats_half;
        logic             link;
        logic [AUX_N-1:0] aux;
    } src_evt_t;

    typedef struct packed {
        logic global_clr;
        logic tx_adv;
        logic tx_more;
        logic rx_drained;
        logic stats_read;
    } side_clr_t;

    function automatic clr_kind_e clr_kind_of(input int bit_idx);
        case (bit_idx)
            B_HOST_ERR, B_TX_DONE, B_RX_DONE, B_STATS: return CLR_BY_STROBE;
            default:                                   return CLR_BY_W1C;
        endcase
    endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_status_pkg::*;
#(
    parameter clr_kind_e KIND = CLR_BY_W1C
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic kill_i,
    input  logic w1c_i,
    input  logic strobe_clr_i,
    output logic q_o
);

    logic clr;

    always_comb begin
        if (KIND == CLR_BY_W1C) clr = w1c_i;
        else                    clr = strobe_clr_i;
    end

    always_ff @(posedge clk) begin
        if (rst)         q_o <= 1'b0;
        else if (kill_i) q_o <= 1'b0;
        else if (set_i)  q_o <= 1'b1;
        else if (clr)    q_o <= 1'b0;
    end

endmodule

// File: rtl/irq_evt_map.sv
module irq_evt_map
    import irq_status_pkg::*;
(
    input  src_evt_t              evt_i,
    input  side_clr_t             side_i,
    output logic [SRC_HI:SRC_LO]  set_o,
    output logic [SRC_HI:SRC_LO]  strobe_clr_o,
    output logic [SRC_HI:SRC_LO]  kill_o
);

    always_comb begin
        set_o                    = '0;
        set_o[B_HOST_ERR]        = evt_i.host_err;
        set_o[B_TX_DONE]         = evt_i.tx_done;
        set_o[B_MAC_CTRL]        = evt_i.mac_ctrl;
        set_o[B_RX_DONE]         = evt_i.rx_done;
        set_o[B_RX_EARLY]        = evt_i.rx_early;
        set_o[B_REQ]             = evt_i.host_req | evt_i.timer;
        set_o[B_STATS]           = evt_i.stats_half;
        set_o[B_LINK]            = evt_i.link;
        set_o[B_AUX0+AUX_N-1:B_AUX0] = evt_i.aux;

        strobe_clr_o             = '0;
        strobe_clr_o[B_HOST_ERR] = side_i.global_clr;
        strobe_clr_o[B_TX_DONE]  = side_i.tx_adv & ~side_i.tx_more;
        strobe_clr_o[B_RX_DONE]  = side_i.rx_drained;
        strobe_clr_o[B_STATS]    = side_i.stats_read;

        kill_o                   = '0;
        kill_o[B_RX_EARLY]       = evt_i.rx_done;
    end

endmodule

// File: rtl/irq_mask_or.sv
module irq_mask_or
    import irq_status_pkg::*;
(
    input  logic [SRC_HI:SRC_LO] stat_i,
    input  logic [SRC_HI:SRC_LO] en_i,
    output logic                 irq_o
);

    assign irq_o = |(stat_i & en_i);

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             stat_wr,
    input  logic             en_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] stat_rdata,
    output logic [REG_W-1:0] en_rdata,
    output logic             irq_o,
    input  logic             ev_host_err,
    input  logic             ev_tx_done,
    input  logic             ev_mac_ctrl,
    input  logic             ev_rx_done,
    input  logic             ev_rx_early,
    input  logic             ev_host_req,
    input  logic             ev_timer,
    input  logic             ev_stats_half,
    input  logic             ev_link,
    input  logic [AUX_N-1:0] ev_aux,
    input  logic             clr_global,
    input  logic             tx_stat_adv,
    input  logic             tx_stat_more,
    input  logic             rx_dma_drained,
    input  logic             stats_read_done
);

    localparam int PAD_W = REG_W - SRC_HI - 1;

    src_evt_t              evt;
    side_clr_t             side;
    logic [SRC_HI:SRC_LO]  set_vec;
    logic [SRC_HI:SRC_LO]  strobe_vec;
    logic [SRC_HI:SRC_LO]  kill_vec;
    logic [SRC_HI:SRC_LO]  w1c_vec;
    logic [SRC_HI:SRC_LO]  stat_q;
    logic [SRC_HI:SRC_LO]  en_q;
    logic                  irq_int;
    logic                  unused_wbits;

    assign evt = '{host_err:   ev_host_err,
                   tx_done:    ev_tx_done,
                   mac_ctrl:   ev_mac_ctrl,
                   rx_done:    ev_rx_done,
                   rx_early:   ev_rx_early,
                   host_req:   ev_host_req,
                   timer:      ev_timer,
                   stats_half: ev_stats_half,
                   link:       ev_link,
                   aux:        ev_aux};

    assign side = '{global_clr: clr_global,
                    tx_adv:     tx_stat_adv,
                    tx_more:    tx_stat_more,
                    rx_drained: rx_dma_drained,
                    stats_read: stats_read_done};

    assign w1c_vec      = stat_wr ? wdata[SRC_HI:SRC_LO] : '0;
    assign unused_wbits = ^{wdata[REG_W-1:SRC_HI+1], wdata[0]};

    irq_evt_map u_map (
        .evt_i        (evt),
        .side_i       (side),
        .set_o        (set_vec),
        .strobe_clr_o (strobe_vec),
        .kill_o       (kill_vec)
    );

    for (genvar b = SRC_LO; b <= SRC_HI; b++) begin : g_src
        irq_src_cell #(.KIND(clr_kind_of(b))) u_cell (
            .clk          (clk),
            .rst          (rst),
            .set_i        (set_vec[b]),
            .kill_i       (kill_vec[b]),
            .w1c_i        (w1c_vec[b]),
            .strobe_clr_i (strobe_vec[b]),
            .q_o          (stat_q[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (en_wr) en_q <= wdata[SRC_HI:SRC_LO];
    end

    irq_mask_or u_or (
        .stat_i (stat_q),
        .en_i   (en_q),
        .irq_o  (irq_int)
    );

    assign irq_o      = irq_int;
    assign stat_rdata = {{PAD_W{1'b0}}, stat_q, irq_int};
    assign en_rdata   = {{PAD_W{1'b0}}, en_q, 1'b0};

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
    import irq_status_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] stat_rdata,
    input logic [REG_W-1:0] en_rdata,
    input logic             irq_o,
    input logic             stat_wr,
    input logic [REG_W-1:0] wdata,
    input logic             ev_host_err,
    input logic             ev_rx_done,
    input logic             ev_link,
    input logic             ev_stats_half,
    input logic             clr_global,
    input logic             tx_stat_adv,
    input logic             tx_stat_more,
    input logic             stats_read_done
);

    // R2: interrupt line reflects the masked status
    a_r2_irq_masked_or: assert property (@(posedge clk) disable iff (rst)
        irq_o == |(stat_rdata[SRC_HI:SRC_LO] & en_rdata[SRC_HI:SRC_LO]));

    // R4: host error survives everything but the global clear
    a_r4_host_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat_rdata[B_HOST_ERR] && !clr_global) |=> stat_rdata[B_HOST_ERR]);

    // R5: transmit done held while queue entries remain or no advance
    a_r5_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (stat_rdata[B_TX_DONE] && !(tx_stat_adv && !tx_stat_more)) |=> stat_rdata[B_TX_DONE]);

    // R8: frame completion retires the early flag and sets receive done
    a_r8_early_retired: assert property (@(posedge clk) disable iff (rst)
        ev_rx_done |=> (!stat_rdata[B_RX_EARLY] && stat_rdata[B_RX_DONE]));

    // R10: statistics read clears bit 7 when no new event arrives
    a_r10_stats_clear: assert property (@(posedge clk) disable iff (rst)
        (stats_read_done && !ev_stats_half) |=> !stat_rdata[B_STATS]);

    // R11: set beats a write-1 acknowledge in the same cycle
    a_r11_link_set_wins: assert property (@(posedge clk) disable iff (rst)
        (ev_link && stat_wr && wdata[B_LINK]) |=> stat_rdata[B_LINK]);

    a_r11_host_set_wins: assert property (@(posedge clk) disable iff (rst)
        ev_host_err |=> stat_rdata[B_HOST_ERR]);

    // R12: unused upper bits stay zero
    a_r12_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (stat_rdata[REG_W-1:SRC_HI+1] == '0) && (en_rdata[REG_W-1:SRC_HI+1] == '0));

endmodule

bind irq_status_ctrl irq_status_chk u_chk (.*);

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        stat_wr, en_wr;
    logic [15:0] wdata;
    logic [15:0] stat_rdata, en_rdata;
    logic        irq_o;
    logic        ev_host_err, ev_tx_done, ev_mac_ctrl, ev_rx_done, ev_rx_early;
    logic        ev_host_req, ev_timer, ev_stats_half, ev_link;
    logic [1:0]  ev_aux;
    logic        clr_global, tx_stat_adv, tx_stat_more, rx_dma_drained, stats_read_done;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 0;
    string tag = "R1";

    logic [10:1] m_stat;
    logic [10:1] m_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_ctrl i_irq_status_ctrl (.*);

    task automatic idle();
        stat_wr = 0; en_wr = 0; wdata = '0;
        ev_host_err = 0; ev_tx_done = 0; ev_mac_ctrl = 0; ev_rx_done = 0;
        ev_rx_early = 0; ev_host_req = 0; ev_timer = 0; ev_stats_half = 0;
        ev_link = 0; ev_aux = '0; clr_global = 0; tx_stat_adv = 0;
        tx_stat_more = 0; rx_dma_drained = 0; stats_read_done = 0;
    endtask

    task automatic model_edge();
        logic [10:1] w;
        logic [10:1] n;
        if (rst) begin
            m_stat = '0;
            m_en   = '0;
            return;
        end
        w = stat_wr ? wdata[10:1] : '0;
        n = m_stat;
        if (ev_host_err) n[1] = 1; else if (clr_global) n[1] = 0;
        if (ev_tx_done) n[2] = 1; else if (tx_stat_adv && !tx_stat_more) n[2] = 0;
        if (ev_mac_ctrl) n[3] = 1; else if (w[3]) n[3] = 0;
        if (ev_rx_done) n[4] = 1; else if (rx_dma_drained) n[4] = 0;
        if (ev_rx_done) n[5] = 0; else if (ev_rx_early) n[5] = 1; else if (w[5]) n[5] = 0;
        if (ev_host_req || ev_timer) n[6] = 1; else if (w[6]) n[6] = 0;
        if (ev_stats_half) n[7] = 1; else if (stats_read_done) n[7] = 0;
        if (ev_link) n[8] = 1; else if (w[8]) n[8] = 0;
        if (ev_aux[0]) n[9] = 1; else if (w[9]) n[9] = 0;
        if (ev_aux[1]) n[10] = 1; else if (w[10]) n[10] = 0;
        m_stat = n;
        if (en_wr) m_en = wdata[10:1];
    endtask

    task automatic compare(string t, string what, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
        end
    endtask

    // one clock: inputs already driven, model updates at the edge, compare at negedge
    task automatic cyc();
        logic [15:0] exp_s;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp_s = {5'b0, m_stat, |(m_stat & m_en)};
        compare(tag, "stat", stat_rdata, exp_s);
        compare(tag, "en", en_rdata, {5'b0, m_en, 1'b0});
        compare(tag, "irq", {15'b0, irq_o}, {15'b0, |(m_stat & m_en)});
        idle();
    endtask

    task automatic wr_stat(logic [15:0] d);
        stat_wr = 1; wdata = d; cyc();
    endtask

    task automatic expect_bit(string t, int idx, logic v);
        compare(t, "bit", {15'b0, stat_rdata[idx]}, {15'b0, v});
    endtask

    initial begin
        idle();
        rst = 1;
        m_stat = '0; m_en = '0;
        tag = "R1"; cyc(); cyc();
        rst = 0; cyc();
        compare("R1", "reset stat", stat_rdata, 16'h0000);

        // R3: masked source still latches, no interrupt
        tag = "R3";
        ev_link = 1; cyc();
        expect_bit("R3", 8, 1);
        compare("R3", "irq masked", {15'b0, irq_o}, 16'h0000);
        en_wr = 1; wdata = 16'h0100; cyc();
        compare("R3", "irq enabled", {15'b0, irq_o}, 16'h0001);
        wr_stat(16'h0100);
        // R3: each single-bit enable gates only its own source
        for (int b = 1; b <= 10; b++) begin
            en_wr = 1; wdata = 16'(1 << b); cyc();
            ev_host_err = 1; ev_tx_done = 1; cyc();
            clr_global = 1; tx_stat_adv = 1; cyc();
        end

        // R2: write to bit 0 ignored, bit 0 tracks masked OR
        tag = "R2";
        en_wr = 1; wdata = 16'h07FE; cyc();
        ev_mac_ctrl = 1; cyc();
        wr_stat(16'h0001);
        expect_bit("R2", 0, 1);
        wr_stat(16'h0008);
        expect_bit("R2", 0, 0);

        // R4: host error
        tag = "R4";
        ev_host_err = 1; cyc();
        wr_stat(16'h0002);
        expect_bit("R4", 1, 1);
        clr_global = 1; cyc();
        expect_bit("R4", 1, 0);

        // R5: transmit done and queue advance
        tag = "R5";
        ev_tx_done = 1; cyc();
        wr_stat(16'h0004);
        expect_bit("R5", 2, 1);
        tx_stat_adv = 1; tx_stat_more = 1; cyc();
        expect_bit("R5", 2, 1);
        tx_stat_adv = 1; cyc();
        expect_bit("R5", 2, 0);

        // R6: write-1 bits; zeros leave them
        tag = "R6";
        ev_mac_ctrl = 1; ev_rx_early = 1; ev_host_req = 1; ev_link = 1; ev_aux = 2'b11; cyc();
        wr_stat(16'h0000);
        compare("R6", "w0 keep", stat_rdata & 16'h0768, 16'h0768);
        wr_stat(16'h0028);
        compare("R6", "partial clr", stat_rdata & 16'h0768, 16'h0740);
        wr_stat(16'h0740);
        compare("R6", "all clr", stat_rdata & 16'h0768, 16'h0000);

        // R7: receive done
        tag = "R7";
        ev_rx_done = 1; cyc();
        wr_stat(16'h0010);
        expect_bit("R7", 4, 1);
        rx_dma_drained = 1; cyc();
        expect_bit("R7", 4, 0);

        // R8: completion retires the early flag, even against a fresh early pulse
        tag = "R8";
        ev_rx_early = 1; cyc();
        expect_bit("R8", 5, 1);
        ev_rx_done = 1; ev_rx_early = 1; cyc();
        expect_bit("R8", 5, 0);
        expect_bit("R8", 4, 1);
        rx_dma_drained = 1; cyc();

        // R9: both request paths
        tag = "R9";
        ev_timer = 1; cyc();
        expect_bit("R9", 6, 1);
        wr_stat(16'h0040);
        ev_host_req = 1; cyc();
        expect_bit("R9", 6, 1);
        wr_stat(16'h0040);

        // R10: statistics
        tag = "R10";
        ev_stats_half = 1; cyc();
        wr_stat(16'h0080);
        expect_bit("R10", 7, 1);
        stats_read_done = 1; cyc();
        expect_bit("R10", 7, 0);

        // R11: set wins against same-cycle clears
        tag = "R11";
        ev_link = 1; stat_wr = 1; wdata = 16'h0100; cyc();
        expect_bit("R11", 8, 1);
        ev_stats_half = 1; stats_read_done = 1; cyc();
        expect_bit("R11", 7, 1);
        ev_host_err = 1; clr_global = 1; cyc();
        expect_bit("R11", 1, 1);
        ev_tx_done = 1; tx_stat_adv = 1; cyc();
        expect_bit("R11", 2, 1);
        ev_aux = 2'b01; stat_wr = 1; wdata = 16'h0200; cyc();
        expect_bit("R11", 9, 1);

        // R12: upper bits
        tag = "R12";
        en_wr = 1; wdata = 16'hFFFF; cyc();
        wr_stat(16'hFFFF);
        compare("R12", "stat upper", stat_rdata & 16'hF800, 16'h0000);
        compare("R12", "en upper", en_rdata & 16'hF800, 16'h0000);

        tag = "R1";
        rst = 1; cyc();
        rst = 0; cyc();
        compare("R1", "reset again", stat_rdata | en_rdata, 16'h0000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule